// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block decides whether a short relative branch is taken and works out the program counter that follows it. For each branch it is given the opcode (a byte in the range 0x20 to 0x2F), a prefix byte (0x00 for none, or the alternate-condition prefix 0x90), a seven-bit flag vector, the program counter already advanced past the displacement byte, and the signed 8-bit displacement. One cycle later it returns the decision, the next program counter, a flag asking the sequencer for one extra execution cycle, and a flag for an encoding the unit does not accept.

Opcode bits [3:1] select one of eight tests and opcode bit 0 inverts the result of the test. With the alternate prefix, three selector values are given other meanings: a half-carry test, an interrupt-mask test and a test that never passes. Every other selector under that prefix is refused as illegal. The displacement byte counts as consumed in every case, so a branch that is not taken simply continues at the supplied program counter.

Top module: `rel_branch_unit`

## Requirements
- R1: While reset is asserted and after it is released, outValid, taken, extraCycle and illegal are 0 and nextPc is 0 until the first request is accepted.
- R2: A request presented with valid high at a rising edge produces outValid high, with its results, after that edge for exactly one cycle. Without valid, outValid is low.
- R3: Selector opcode[3:1] = 0 always passes the test. Opcode bit 0 inverts the test result for every selector, so 0x20 is taken and 0x21 is not. The flag vector is laid out as flags[0]=C, flags[1]=Z, flags[2]=N, flags[3]=V, flags[4]=H, flags[5]=interrupt mask 0, flags[6]=interrupt mask 1.
- R4: Without a prefix, selector 1 passes when neither C nor Z is set, and selector 2 passes when C is clear.
- R5: Without a prefix, selector 3 passes when Z is clear, selector 4 passes when V is clear, and selector 5 passes when N is clear.
- R6: Without a prefix, selector 6 passes when Z is clear and N equals V, and selector 7 passes when N equals V.
- R7: With prefix 0x90, selector 4 passes when H is clear, selector 6 passes when both interrupt-mask bits are clear, and selector 7 never passes. Opcode bit 0 still inverts each of these.
- R8: The unit reports illegal, with taken and extraCycle at 0 and nextPc equal to the supplied PC, for any of these: prefix 0x90 with selector 0, 1, 2, 3 or 5; a prefix other than 0x00 or 0x90; or an opcode whose upper nibble is not 2.
- R9: A taken branch gives nextPc = pc + sign-extended displacement, wrapping modulo 2^PC_W, and sets extraCycle.
- R10: A legal branch that is not taken gives nextPc equal to the supplied PC, with extraCycle at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| valid | input | 1 | A branch request is presented this cycle |
| opcode | input | 8 | Branch opcode byte |
| prefix | input | 8 | Prefix byte, 0x00 when there is none |
| flags | input | 7 | Condition flags, laid out as in R3 |
| pc | input | PC_W (16) | Address after the displacement byte |
| disp | input | 8 | Signed displacement |
| outValid | output | 1 | Results below belong to the last request |
| taken | output | 1 | Branch taken |
| nextPc | output | PC_W (16) | Program counter to continue at |
| extraCycle | output | 1 | One added cycle of execution time |
| illegal | output | 1 | Encoding refused |

## Verification
Each selector is driven with flag sets on both sides of its test, and with both values of opcode bit 0. This separates a wrong selector decode from a missing or misplaced inversion. Signed tests are tried with N and V equal and unequal, and with Z set while N equals V, so that the Z term cannot be mistaken for the N xor V term. Under the alternate prefix, the same selector values are tried with the half-carry and mask bits toggled, and also with every flag set, so that a fall-through into the unprefixed tests shows up. Displacements of 0x80, 0xFF and a forward step across the top of the address range show whether the sign extension and the wrap are right. Illegal encodings are checked for an unchanged PC.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
  localparam logic [7:0] PREFIX_NONE = 8'h00;
  localparam logic [7:0] PREFIX_ALT  = 8'h90;
  localparam int FLAG_W = 7;
  localparam int F_C  = 0;
  localparam int F_Z  = 1;
  localparam int F_N  = 2;
  localparam int F_V  = 3;
  localparam int F_H  = 4;
  localparam int F_M0 = 5;
  localparam int F_M1 = 6;

  typedef struct packed {
    logic load;
    logic take;
    logic bad;
  } rbuStrobe_t;
endpackage

// File: rtl/rbu_ctrl.sv
module rbu_ctrl
  import rbu_pkg::*;
(
  input  logic              valid,
  input  logic [7:0]        opcode,
  input  logic [7:0]        prefix,
  input  logic [FLAG_W-1:0] flags,
  output rbuStrobe_t        strobe
);
  logic [2:0] sel;
  logic       inRange, hasAlt, noPre, legalSel, cond, bad;
  logic       signLess;

  assign sel      = opcode[3:1];
  assign inRange  = (opcode[7:4] == 4'h2);
  assign hasAlt   = (prefix == PREFIX_ALT);
  assign noPre    = (prefix == PREFIX_NONE);
  assign signLess = flags[F_N] ^ flags[F_V];

  always_comb begin
    cond     = 1'b0;
    legalSel = 1'b1;
    if (hasAlt) begin
      case (sel)
        3'd4:    cond = !flags[F_H];
        3'd6:    cond = !(flags[F_M0] | flags[F_M1]);
        3'd7:    cond = 1'b0;
        default: legalSel = 1'b0;
      endcase
    end else begin
      case (sel)
        3'd0:    cond = 1'b1;
        3'd1:    cond = !(flags[F_C] | flags[F_Z]);
        3'd2:    cond = !flags[F_C];
        3'd3:    cond = !flags[F_Z];
        3'd4:    cond = !flags[F_V];
        3'd5:    cond = !flags[F_N];
        3'd6:    cond = !(flags[F_Z] | signLess);
        default: cond = !signLess;
      endcase
    end
  end

  assign bad         = !inRange || !(noPre || hasAlt) || !legalSel;
  assign strobe.load = valid;
  assign strobe.bad  = bad;
  assign strobe.take = !bad && (cond ^ opcode[0]);
endmodule

// File: rtl/rbu_datapath.sv
module rbu_datapath
  import rbu_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rbuStrobe_t        strobe,
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  output logic              outValid,
  output logic              taken,
  output logic [PC_W-1:0]   nextPc,
  output logic              extraCycle,
  output logic              illegal
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] dispExt;
  logic [PC_W-1:0] target;

  assign dispExt = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign target  = pc + dispExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      taken      <= 1'b0;
      nextPc     <= '0;
      extraCycle <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        taken      <= strobe.take;
        extraCycle <= strobe.take;
        illegal    <= strobe.bad;
        nextPc     <= strobe.take ? target : pc;
      end
    end
  end

  // R8: an illegal result is never also a taken branch
  p_no_take_when_bad_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $onehot0({taken, illegal}));

  // R10: a request that is not taken leaves the PC where it was presented
  p_hold_pc_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && !strobe.take |=> nextPc == $past(pc));
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
  import rbu_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  logic [7:0]        opcode,
  input  logic [7:0]        prefix,
  input  logic [6:0]        flags,
  input  logic [PC_W-1:0]   pc,
  input  logic [7:0]        disp,
  output logic              outValid,
  output logic              taken,
  output logic [PC_W-1:0]   nextPc,
  output logic              extraCycle,
  output logic              illegal
);
  rbuStrobe_t strobe;

  rbu_ctrl u_ctrl (
    .valid  (valid),
    .opcode (opcode),
    .prefix (prefix),
    .flags  (flags),
    .strobe (strobe)
  );

  rbu_datapath #(.PC_W(PC_W), .DISP_W(8)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pc         (pc),
    .disp       (disp),
    .outValid   (outValid),
    .taken      (taken),
    .nextPc     (nextPc),
    .extraCycle (extraCycle),
    .illegal    (illegal)
  );

  // R2: one result per request, one cycle later
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> outValid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> !outValid);

  // R3: the unconditional opcode without prefix is always taken
  p_always_r3: assert property (@(posedge clk) disable iff (!rstN)
    valid && prefix == 8'h00 && opcode == 8'h20 |=> taken && extraCycle);

  // R8: alternate prefix with selector 0 is refused
  p_alt_sel0_r8: assert property (@(posedge clk) disable iff (!rstN)
    valid && prefix == 8'h90 && opcode[7:1] == 7'h10 |=> illegal && !taken);
endmodule

// File: tb/tb_rel_branch_unit.sv
module tb_rel_branch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16;
  localparam logic [6:0] FC = 7'h01, FZ = 7'h02, FN = 7'h04, FV = 7'h08,
                         FH = 7'h10, FM0 = 7'h20, FM1 = 7'h40;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            valid = 1'b0;
  logic [7:0]      opcode = '0;
  logic [7:0]      prefix = '0;
  logic [6:0]      flags = '0;
  logic [PC_W-1:0] pc = '0;
  logic [7:0]      disp = '0;
  logic            outValid, taken, extraCycle, illegal;
  logic [PC_W-1:0] nextPc;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rel_branch_unit #(.PC_W(PC_W)) dut (
    .clk(clk), .rstN(rstN), .valid(valid), .opcode(opcode), .prefix(prefix),
    .flags(flags), .pc(pc), .disp(disp), .outValid(outValid), .taken(taken),
    .nextPc(nextPc), .extraCycle(extraCycle), .illegal(illegal)
  );

  task automatic checkEq(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drives one request and checks the registered result one cycle later
  task automatic doBranch(input string tag, input logic [7:0] op,
                          input logic [7:0] pre, input logic [6:0] fl,
                          input logic [PC_W-1:0] pcv, input logic [7:0] dv,
                          input bit expTaken, input bit expBad,
                          input logic [PC_W-1:0] expPc);
    string pcTag;
    pcTag = expBad ? "R8" : (expTaken ? "R9" : "R10");
    @(negedge clk);
    valid = 1'b1; opcode = op; prefix = pre; flags = fl; pc = pcv; disp = dv;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    checkEq("R2", "outValid", 32'(outValid), 32'd1);
    checkEq(tag, $sformatf("taken op %h pre %h fl %h", op, pre, fl),
            32'(taken), 32'(expTaken));
    checkEq(expBad ? "R8" : tag, "illegal", 32'(illegal), 32'(expBad));
    checkEq(pcTag, "extraCycle", 32'(extraCycle), 32'(expTaken));
    checkEq(pcTag, "nextPc", 32'(nextPc), 32'(expPc));
  endtask

  task automatic tReset;
    checkEq("R1", "outValid", 32'(outValid), 32'd0);
    checkEq("R1", "taken", 32'(taken), 32'd0);
    checkEq("R1", "extraCycle", 32'(extraCycle), 32'd0);
    checkEq("R1", "illegal", 32'(illegal), 32'd0);
    checkEq("R1", "nextPc", 32'(nextPc), 32'd0);
  endtask

  task automatic tLatency;
    doBranch("R3", 8'h20, 8'h00, 7'h00, 16'h2000, 8'h04, 1, 0, 16'h2004);
    @(negedge clk);
    checkEq("R2", "outValid after idle cycle", 32'(outValid), 32'd0);
  endtask

  task automatic tUncond;
    doBranch("R3", 8'h20, 8'h00, 7'h7F, 16'h1000, 8'h10, 1, 0, 16'h1010);
    doBranch("R3", 8'h21, 8'h00, 7'h00, 16'h1000, 8'h10, 0, 0, 16'h1000);
  endtask

  task automatic tUnsigned;
    doBranch("R4", 8'h22, 8'h00, 7'h00, 16'h1000, 8'h20, 1, 0, 16'h1020);
    doBranch("R4", 8'h22, 8'h00, FC,    16'h1000, 8'h20, 0, 0, 16'h1000);
    doBranch("R4", 8'h22, 8'h00, FZ,    16'h1000, 8'h20, 0, 0, 16'h1000);
    doBranch("R4", 8'h23, 8'h00, FZ,    16'h1000, 8'h20, 1, 0, 16'h1020);
    doBranch("R4", 8'h24, 8'h00, FC,    16'h1000, 8'h20, 0, 0, 16'h1000);
    doBranch("R4", 8'h24, 8'h00, FZ,    16'h1000, 8'h20, 1, 0, 16'h1020);
    doBranch("R4", 8'h25, 8'h00, FC,    16'h1000, 8'h20, 1, 0, 16'h1020);
  endtask

  task automatic tFlags;
    doBranch("R5", 8'h26, 8'h00, FZ,    16'h3000, 8'h08, 0, 0, 16'h3000);
    doBranch("R5", 8'h27, 8'h00, FZ,    16'h3000, 8'h08, 1, 0, 16'h3008);
    doBranch("R5", 8'h28, 8'h00, FV,    16'h3000, 8'h08, 0, 0, 16'h3000);
    doBranch("R5", 8'h29, 8'h00, FV,    16'h3000, 8'h08, 1, 0, 16'h3008);
    doBranch("R5", 8'h2A, 8'h00, FN,    16'h3000, 8'h08, 0, 0, 16'h3000);
    doBranch("R5", 8'h2A, 8'h00, FV,    16'h3000, 8'h08, 1, 0, 16'h3008);
    doBranch("R5", 8'h2B, 8'h00, 7'h00, 16'h3000, 8'h08, 0, 0, 16'h3000);
  endtask

  task automatic tSigned;
    doBranch("R6", 8'h2C, 8'h00, FN|FV, 16'h4000, 8'h02, 1, 0, 16'h4002);
    doBranch("R6", 8'h2C, 8'h00, FN,    16'h4000, 8'h02, 0, 0, 16'h4000);
    doBranch("R6", 8'h2C, 8'h00, FZ,    16'h4000, 8'h02, 0, 0, 16'h4000);
    doBranch("R6", 8'h2D, 8'h00, FV,    16'h4000, 8'h02, 1, 0, 16'h4002);
    doBranch("R6", 8'h2E, 8'h00, FN|FV|FZ, 16'h4000, 8'h02, 1, 0, 16'h4002);
    doBranch("R6", 8'h2E, 8'h00, FV,    16'h4000, 8'h02, 0, 0, 16'h4000);
    doBranch("R6", 8'h2F, 8'h00, FN,    16'h4000, 8'h02, 1, 0, 16'h4002);
  endtask

  task automatic tAlternate;
    doBranch("R7", 8'h28, 8'h90, FH,    16'h5000, 8'h30, 0, 0, 16'h5000);
    doBranch("R7", 8'h28, 8'h90, FV,    16'h5000, 8'h30, 1, 0, 16'h5030);
    doBranch("R7", 8'h29, 8'h90, FH,    16'h5000, 8'h30, 1, 0, 16'h5030);
    doBranch("R7", 8'h2C, 8'h90, FM0,   16'h5000, 8'h30, 0, 0, 16'h5000);
    doBranch("R7", 8'h2C, 8'h90, FN,    16'h5000, 8'h30, 1, 0, 16'h5030);
    doBranch("R7", 8'h2D, 8'h90, FM1,   16'h5000, 8'h30, 1, 0, 16'h5030);
    doBranch("R7", 8'h2E, 8'h90, 7'h00, 16'h5000, 8'h30, 0, 0, 16'h5000);
    doBranch("R7", 8'h2F, 8'h90, 7'h7F, 16'h5000, 8'h30, 1, 0, 16'h5030);
  endtask

  task automatic tIllegal;
    doBranch("R8", 8'h20, 8'h90, 7'h00, 16'h6000, 8'h10, 0, 1, 16'h6000);
    doBranch("R8", 8'h26, 8'h90, 7'h00, 16'h6000, 8'h10, 0, 1, 16'h6000);
    doBranch("R8", 8'h2A, 8'h90, 7'h00, 16'h6000, 8'h10, 0, 1, 16'h6000);
    doBranch("R8", 8'h20, 8'h72, 7'h00, 16'h6000, 8'h10, 0, 1, 16'h6000);
    doBranch("R8", 8'h30, 8'h00, 7'h00, 16'h6000, 8'h10, 0, 1, 16'h6000);
  endtask

  task automatic tWrap;
    doBranch("R9", 8'h20, 8'h00, 7'h00, 16'hFFFE, 8'h05, 1, 0, 16'h0003);
    doBranch("R9", 8'h20, 8'h00, 7'h00, 16'h0002, 8'h80, 1, 0, 16'hFF82);
    doBranch("R9", 8'h20, 8'h00, 7'h00, 16'h0100, 8'hFF, 1, 0, 16'h00FF);
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tReset;
    rstN = 1'b1;
    @(negedge clk);
    tReset;
    tLatency;
    tUncond;
    tUnsigned;
    tFlags;
    tSigned;
    tAlternate;
    tIllegal;
    tWrap;
    finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish;
  end
endmodule